// File: doc/BRIEF.md
# Flash Emulation RAM Overlay Controller

This block lets software tune constant data held in flash by running it from RAM. A 4 KB window of on-chip RAM can be laid over any one of eight 4 KB blocks in the lowest 32 KB of the flash address space. While the overlay is active, CPU accesses to the chosen flash block are sent to the overlay RAM. The same RAM also stays reachable at its own window address.

A small control register is written over a simple register bus and can be read back on the same bus. The CPU address decode is purely combinational. The block also gates the flash program and erase mode requests. While emulation is switched on, neither mode can be entered for any flash block. After tuning, software clears the enable bit. The overlay is then released at once, and the tuned data can be programmed into the real flash block.

Top module: `flash_overlay_ctl`

## Requirements
- R1: Reset is synchronous and active high. It clears the control register, so the read-back is 0x00, `protect` is low, no access is redirected, and program and erase requests pass through.
- R2: A write (`reg_wr` high at a rising edge) loads the control register from `reg_wdata`. Bit 7 is the enable bit, bit 4 is the area-select bit and bits 2:0 are the block number. The new value acts from the next cycle on. `reg_rdata` returns these three fields in the same positions, and reads 0 in bits 6:5 and 3.
- R3: When enable is 1 and area-select is 0, a valid access whose address lies in `N*0x1000` to `N*0x1000+0xFFF` raises `ram_cs` and lowers `flash_cs`, where N is the block number. `ram_addr` then equals address bits 11:0.
- R4: A valid access below 0x040000 that is not redirected raises `flash_cs`, and `flash_addr` equals address bits 17:0. Addresses from 0x008000 upward are never redirected.
- R5: A valid access in 0xFFFF8000 to 0xFFFF8FFF always raises `ram_cs`, whatever the register holds.
- R6: `protect` equals the enable bit. `pgm_mode` equals `pgm_req` and `ers_mode` equals `ers_req` while `protect` is low; both are forced low while `protect` is high.
- R7: When area-select is 1, no access is redirected. Program and erase protection still follows the enable bit.
- R8: A write that clears enable makes accesses to the formerly overlaid block go to flash again from the next cycle, and program/erase requests pass from that cycle too.
- R9: An access with `cpu_valid` low, or with an address outside both the flash range and the RAM window, raises neither chip select. `flash_cs` and `ram_cs` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| cpu_valid | input | 1 | CPU access valid |
| cpu_addr | input | 32 | CPU byte address |
| flash_cs | output | 1 | Access steered to the flash array |
| flash_addr | output | 18 | Flash array offset |
| ram_cs | output | 1 | Access steered to the overlay RAM |
| ram_addr | output | 12 | Overlay RAM offset |
| pgm_req | input | 1 | Request to enter program mode |
| ers_req | input | 1 | Request to enter erase mode |
| pgm_mode | output | 1 | Program mode entry after gating |
| ers_mode | output | 1 | Erase mode entry after gating |
| protect | output | 1 | Program/erase protection active |

## Verification
The risky case is a register write that lands in the same cycle as a CPU access to the overlaid block, or as a program or erase request. The bench drives a write together with an access and a request in one cycle. It does this both when the overlay is switched on and when it is switched off. The cycle of the write must still be steered by the old register value, and the next cycle by the new one. A cycle-by-cycle reference model kept in the bench judges each cycle, and a sweep over all block numbers repeats these checks.

// File: rtl/fovl_pkg.sv
package fovl_pkg;

    localparam int REG_W    = 8;
    localparam int EN_BIT   = 7;
    localparam int AREA_BIT = 4;
    localparam int SEL_LSB  = 0;
    localparam int SEL_W    = 3;

    typedef struct packed {
        logic             en;
        logic             area;
        logic [SEL_W-1:0] sel;
    } ovl_cfg_t;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_RAM   = 2'd2
    } tgt_e;

    function automatic logic [REG_W-1:0] pack_cfg(input ovl_cfg_t c);
        logic [REG_W-1:0] w;
        w                    = '0;
        w[EN_BIT]            = c.en;
        w[AREA_BIT]          = c.area;
        w[SEL_LSB +: SEL_W]  = c.sel;
        return w;
    endfunction

    function automatic ovl_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        ovl_cfg_t c;
        c.en   = w[EN_BIT];
        c.area = w[AREA_BIT];
        c.sel  = w[SEL_LSB +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/fovl_regs.sv
module fovl_regs
    import fovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ovl_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= unpack_cfg(wdata);
        end
    end

    assign rdata = pack_cfg(cfg);

endmodule

// File: rtl/fovl_decode.sv
module fovl_decode
    import fovl_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                FLASH_AW = 18,
    parameter int                BLK_AW   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_8000
) (
    input  ovl_cfg_t              cfg,
    input  logic                  valid,
    input  logic [ADDR_W-1:0]     addr,
    output tgt_e                  tgt,
    output logic [FLASH_AW-1:0]   flash_off,
    output logic [BLK_AW-1:0]     ram_off
);

    localparam int SHADOW_AW = BLK_AW + SEL_W;
    localparam int TAG_W     = ADDR_W - BLK_AW;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:BLK_AW];

    logic in_window;
    logic in_flash;
    logic in_shadow;
    logic hit_sel;
    logic redirect;

    assign in_window = (addr[ADDR_W-1:BLK_AW] == WIN_TAG);
    assign in_flash  = (addr[ADDR_W-1:FLASH_AW] == '0);
    assign in_shadow = (addr[ADDR_W-1:SHADOW_AW] == '0);
    assign hit_sel   = (addr[SHADOW_AW-1:BLK_AW] == cfg.sel);
    assign redirect  = cfg.en & ~cfg.area & in_shadow & hit_sel;

    always_comb begin
        if (!valid) begin
            tgt = TGT_NONE;
        end else if (in_window || redirect) begin
            tgt = TGT_RAM;
        end else if (in_flash) begin
            tgt = TGT_FLASH;
        end else begin
            tgt = TGT_NONE;
        end
    end

    assign flash_off = addr[FLASH_AW-1:0];
    assign ram_off   = addr[BLK_AW-1:0];

endmodule

// File: rtl/fovl_pe_gate.sv
module fovl_pe_gate #(
    parameter int NREQ = 2
) (
    input  logic            lock,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant
);

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        assign grant[i] = req[i] & ~lock;
    end

endmodule

// File: rtl/flash_overlay_ctl.sv
module flash_overlay_ctl
    import fovl_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                FLASH_AW = 18,
    parameter int                BLK_AW   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_8000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                cpu_valid,
    input  logic [ADDR_W-1:0]   cpu_addr,
    output logic                flash_cs,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic                ram_cs,
    output logic [BLK_AW-1:0]   ram_addr,
    input  logic                pgm_req,
    input  logic                ers_req,
    output logic                pgm_mode,
    output logic                ers_mode,
    output logic                protect
);

    ovl_cfg_t   cfg;
    tgt_e       tgt;
    logic [1:0] pe_req;
    logic [1:0] pe_grant;

    fovl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    fovl_decode #(
        .ADDR_W   (ADDR_W),
        .FLASH_AW (FLASH_AW),
        .BLK_AW   (BLK_AW),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .cfg       (cfg),
        .valid     (cpu_valid),
        .addr      (cpu_addr),
        .tgt       (tgt),
        .flash_off (flash_addr),
        .ram_off   (ram_addr)
    );

    assign pe_req = {ers_req, pgm_req};

    fovl_pe_gate #(
        .NREQ (2)
    ) u_pe_gate (
        .lock  (cfg.en),
        .req   (pe_req),
        .grant (pe_grant)
    );

    assign flash_cs = (tgt == TGT_FLASH);
    assign ram_cs   = (tgt == TGT_RAM);
    assign pgm_mode = pe_grant[0];
    assign ers_mode = pe_grant[1];
    assign protect  = cfg.en;

endmodule

// File: rtl/fovl_checker.sv
module fovl_checker #(
    parameter int                ADDR_W   = 32,
    parameter int                FLASH_AW = 18,
    parameter int                BLK_AW   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_8000
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     reg_wr,
    input logic                     wr_en_bit,
    input logic                     area_flag,
    input logic                     cpu_valid,
    input logic [ADDR_W-1:BLK_AW]   addr_tag,
    input logic                     flash_cs,
    input logic                     ram_cs,
    input logic                     protect,
    input logic                     pgm_mode,
    input logic                     ers_mode
);

    localparam int SHADOW_AW = BLK_AW + fovl_pkg::SEL_W;
    localparam logic [ADDR_W-BLK_AW-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:BLK_AW];

    logic in_window;
    logic high_flash;
    logic low_shadow;

    assign in_window  = (addr_tag == WIN_TAG);
    assign high_flash = (addr_tag[ADDR_W-1:FLASH_AW] == '0) &&
                        (addr_tag[FLASH_AW-1:SHADOW_AW] != '0);
    assign low_shadow = (addr_tag[ADDR_W-1:SHADOW_AW] == '0);

    // R9: chip selects are exclusive
    assert_cs_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(flash_cs && ram_cs));

    // R6: no program or erase entry under protection
    assert_pe_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        protect |-> (!pgm_mode && !ers_mode));

    // R2: a write sets the protection state for the next cycle
    assert_enable_write_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (protect == $past(wr_en_bit)));

    // R5: the RAM window is always reachable
    assert_window_ram_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && in_window) |-> ram_cs);

    // R4: flash at or above the shadowed region is never redirected
    assert_high_flash_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && high_flash) |-> (flash_cs && !ram_cs));

    // R7: area-select blocks any redirect
    assert_area_no_overlay_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && area_flag && low_shadow) |-> (flash_cs && !ram_cs));

endmodule

bind flash_overlay_ctl fovl_checker #(
    .ADDR_W   (ADDR_W),
    .FLASH_AW (FLASH_AW),
    .BLK_AW   (BLK_AW),
    .WIN_BASE (WIN_BASE)
) u_fovl_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .wr_en_bit (reg_wdata[fovl_pkg::EN_BIT]),
    .area_flag (reg_rdata[fovl_pkg::AREA_BIT]),
    .cpu_valid (cpu_valid),
    .addr_tag  (cpu_addr[ADDR_W-1:BLK_AW]),
    .flash_cs  (flash_cs),
    .ram_cs    (ram_cs),
    .protect   (protect),
    .pgm_mode  (pgm_mode),
    .ers_mode  (ers_mode)
);

// File: tb/test_flash_overlay_ctl.sv
module test_flash_overlay_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        cpu_valid;
    logic [31:0] cpu_addr;
    logic        flash_cs;
    logic [17:0] flash_addr;
    logic        ram_cs;
    logic [11:0] ram_addr;
    logic        pgm_req;
    logic        ers_req;
    logic        pgm_mode;
    logic        ers_mode;
    logic        protect;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    bit m_en;
    bit m_area;
    int m_sel;

    always #5 clk = ~clk;

    flash_overlay_ctl i_flash_overlay_ctl (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cpu_valid  (cpu_valid),
        .cpu_addr   (cpu_addr),
        .flash_cs   (flash_cs),
        .flash_addr (flash_addr),
        .ram_cs     (ram_cs),
        .ram_addr   (ram_addr),
        .pgm_req    (pgm_req),
        .ers_req    (ers_req),
        .pgm_mode   (pgm_mode),
        .ers_mode   (ers_mode),
        .protect    (protect)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive after the falling edge, compare before the rising edge,
    // then advance the model as the rising edge does
    task automatic step(input string tag, input bit r, input bit wr,
                        input logic [7:0] wd, input bit v, input logic [31:0] a,
                        input bit pr, input bit er);
        bit in_win, in_fl, redir, e_ram, e_fl;
        int e_rd;
        @(negedge clk);
        rst = r; reg_wr = wr; reg_wdata = wd;
        cpu_valid = v; cpu_addr = a; pgm_req = pr; ers_req = er;
        #4;
        in_win = (a >= 32'hFFFF_8000) && (a <= 32'hFFFF_8FFF);
        in_fl  = (a < 32'h0004_0000);
        redir  = m_en && !m_area && (a < 32'h0000_8000) && ((a / 4096) == m_sel);
        e_ram  = v && (in_win || redir);
        e_fl   = v && in_fl && !e_ram;
        e_rd   = (m_en ? 128 : 0) + (m_area ? 16 : 0) + m_sel;
        check(tag, "ram_cs",   ram_cs,   e_ram);
        check(tag, "flash_cs", flash_cs, e_fl);
        if (e_ram) check(tag, "ram_addr",   ram_addr,   a % 4096);
        if (e_fl)  check(tag, "flash_addr", flash_addr, a % 262144);
        check(tag, "protect",   protect,   m_en);
        check(tag, "pgm_mode",  pgm_mode,  pr && !m_en);
        check(tag, "ers_mode",  ers_mode,  er && !m_en);
        check(tag, "reg_rdata", reg_rdata, e_rd);
        @(posedge clk);
        if (r) begin
            m_en = 0; m_area = 0; m_sel = 0;
        end else if (wr) begin
            m_en = wd[7]; m_area = wd[4]; m_sel = wd[2:0];
        end
    endtask

    task automatic acc(input string tag, input logic [31:0] a, input bit pr, input bit er);
        step(tag, 0, 0, 8'h00, 1, a, pr, er);
    endtask

    task automatic wr_reg(input string tag, input logic [7:0] wd, input logic [31:0] a);
        step(tag, 0, 1, wd, 1, a, 1, 1);
    endtask

    initial begin
        rst = 1; reg_wr = 0; reg_wdata = 0; cpu_valid = 0; cpu_addr = 0;
        pgm_req = 0; ers_req = 0;
        m_en = 0; m_area = 0; m_sel = 0;
        repeat (2) @(posedge clk);

        // R1: reset state
        step("R1", 1, 0, 8'h00, 1, 32'h0000_1000, 1, 1);
        acc("R1", 32'h0000_1000, 1, 1);

        // R2 / R7: all bits written, area-select blocks overlay
        wr_reg("R2", 8'hFF, 32'h0000_7004);
        acc("R2", 32'h0000_0000, 0, 0);
        acc("R7", 32'h0000_7004, 1, 1);
        acc("R7", 32'h0000_0010, 1, 0);

        // R3 / R4 / R5 / R9 with block 1 overlaid; write cycle uses old state
        wr_reg("R2", 8'h81, 32'h0000_1010);
        acc("R3", 32'h0000_1010, 0, 0);
        acc("R3", 32'h0000_1FFF, 0, 0);
        acc("R4", 32'h0000_2000, 0, 0);
        acc("R4", 32'h0000_0FFF, 0, 0);
        acc("R4", 32'h0000_9010, 0, 0);
        acc("R4", 32'h0003_F000, 0, 0);
        acc("R9", 32'h0004_0000, 0, 0);
        acc("R5", 32'hFFFF_8123, 0, 0);
        acc("R9", 32'hFFFF_9000, 0, 0);
        acc("R9", 32'hFFFF_7FFF, 0, 0);
        step("R9", 0, 0, 8'h00, 0, 32'h0000_1000, 0, 0);
        acc("R6", 32'h0000_3000, 1, 1);

        // block 7 and the boundary just above the shadowed region
        wr_reg("R2", 8'h87, 32'h0000_0000);
        acc("R3", 32'h0000_7ABC, 0, 0);
        acc("R4", 32'h0000_8ABC, 0, 0);

        // R8: release in the same cycle as an access and requests
        wr_reg("R8", 8'h07, 32'h0000_7ABC);
        acc("R8", 32'h0000_7ABC, 1, 1);
        acc("R5", 32'hFFFF_8FFF, 0, 0);

        // sweep of every block number against every block
        for (int b = 0; b < 8; b++) begin
            wr_reg("R3", 8'h80 | 8'(b), 32'h0000_0000);
            for (int t = 0; t < 8; t++) begin
                acc("R3", 32'(t * 4096 + 12'h5A4), t[0], t[1]);
            end
        end

        // R1: reset in mid-run clears the register
        wr_reg("R2", 8'h83, 32'h0000_3000);
        step("R1", 1, 0, 8'h00, 1, 32'h0000_3000, 1, 1);
        acc("R1", 32'h0000_3000, 1, 1);
        acc("R1", 32'h0000_0000, 0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule